// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counting Timer

A register-mapped timer peripheral with two or three independent 32-bit channels. Each channel holds a reload value, a live down-counter and a 16-bit control word. A single shared start byte carries one run bit per channel, so software can start or stop any mix of channels with one write.

A running channel divides the peripheral clock by a power of four, chosen per channel, and decrements its counter once per divided period. When the counter is already zero at a count step, it reloads from the reload register instead and raises a sticky underflow flag. Periodic operation therefore needs no software rewrite. Each channel drives its own interrupt line, which is high while the flag and that channel's interrupt enable are both set. Software acknowledges an event by rewriting the control word with the flag bit at zero.

The bus is a simple synchronous port. Writes take effect at the clock edge where `bus_sel` and `bus_we` are high. A read's data appears on `bus_rdata` from the following edge.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset the start byte and every control word read 0, and every reload and counter register reads 0xFFFFFFFF.
- R2: The start byte is at byte offset 4. Channel n's reload register is at 8+12n, its counter at 12+12n and its control word at 16+12n. Size code 0 is byte, 1 is halfword and 2 is word. A write lands only when its size matches the target's width: byte for the start byte, word for reload and counter, halfword for control. Read data is zero-extended and is registered one cycle after the read. Unmapped offsets read 0.
- R3: Start-byte bit n runs channel n while set. A channel's run bit has no effect on any other channel.
- R4: A stopped channel holds its counter. Writes to the counter store the value as written. Clearing the run bit resets that channel's divider, so the divider restarts from zero on the next start.
- R5: A running channel steps on every D-th clock edge after the edge that set its run bit, where D is the selected divisor. A step decrements a nonzero counter. A step on a zero counter loads the reload value and sets the underflow flag.
- R6: Control bits 2:0 select D: codes 0, 1, 2, 3 and 4 give 4, 16, 64, 256 and 1024. Codes 5, 6 and 7 give 4.
- R7: Control bit 8 is the underflow flag. A control write with bit 8 at 0 clears it, a write with bit 8 at 1 leaves it unchanged, and a hardware set in the same cycle as a clearing write wins.
- R8: Interrupt line n is high exactly when channel n's flag and its control bit 5 (interrupt enable) are both 1.
- R9: Control bits other than 8, 5 and 2:0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte offset from the peripheral base |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Registered read data, zero-extended |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
A wrong divider phase or a missed reload shows up as a counter value that is off after a run of a known number of edges. It also shows up as a flag set one step early or late, and the bench sees this at the first read after the channel stops. A flag that fails to stick or to clear appears on the interrupt line in the same cycle as the control write that should have changed it. Cross-channel coupling appears as a changed counter on a channel that was never started.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW        = 32;
  localparam int CW        = 16;
  localparam int START_OFS = 4;
  localparam int CH_BASE   = 8;
  localparam int CH_STRIDE = 12;
  localparam int FLAG_BIT  = 8;
  localparam int IE_BIT    = 5;
  localparam int DIV_W     = 10;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } bus_size_e;

  // log2 of the divisor for a prescaler code; reserved codes act as code 0
  function automatic logic [3:0] div_log2(input logic [2:0] code);
    case (code)
      3'd1:    div_log2 = 4'd4;
      3'd2:    div_log2 = 4'd6;
      3'd3:    div_log2 = 4'd8;
      3'd4:    div_log2 = 4'd10;
      default: div_log2 = 4'd2;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] limit;

  // 1 << 10 wraps to 0 in DIV_W bits, so the subtraction yields 1023
  assign limit = (DIV_W'(1) << div_log2(code)) - DIV_W'(1);
  assign tick  = run && (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run)  phase_q <= '0;
    else if (tick)    phase_q <= '0;
    else              phase_q <= phase_q + DIV_W'(1);
  end

  // r4: a stopped divider sits at zero
  a_r4_div_cleared: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          rld_we,
  input  logic          cnt_we,
  input  logic          ctl_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rld_q,
  output logic [DW-1:0] cnt_q,
  output logic [CW-1:0] ctl_rd,
  output logic          irq
);
  logic       tick;
  logic [2:0] code_q;
  logic       ie_q;
  logic       flag_q;
  logic       wrap;

  tmr_prescale i_presc (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .code (code_q),
    .tick (tick)
  );

  assign wrap = tick && (cnt_q == '0) && !cnt_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q  <= '1;
      cnt_q  <= '1;
      code_q <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (rld_we) rld_q <= wdata;
      if (cnt_we)     cnt_q <= wdata;
      else if (wrap)  cnt_q <= rld_q;
      else if (tick)  cnt_q <= cnt_q - DW'(1);
      if (ctl_we) begin
        code_q <= wdata[2:0];
        ie_q   <= wdata[IE_BIT];
      end
      flag_q <= wrap || (flag_q && !(ctl_we && !wdata[FLAG_BIT]));
    end
  end

  always_comb begin
    ctl_rd           = '0;
    ctl_rd[2:0]      = code_q;
    ctl_rd[IE_BIT]   = ie_q;
    ctl_rd[FLAG_BIT] = flag_q;
  end

  assign irq = flag_q && ie_q;

  // r4: no run, no write -> counter holds
  a_r4_stopped_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we) |=> $stable(cnt_q));
  // r7: only a control write can drop the flag
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !ctl_we) |=> flag_q);
  // r5: a new flag follows a step taken at zero
  a_r5_flag_from_zero: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !cnt_we && cnt_q != '0) |=> !flag_q);
  // r5: a nonzero counter moves down by at most one per edge
  a_r5_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (!cnt_we && cnt_q != '0) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - DW'(1)));
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    irq
);
  localparam logic [ADDR_W-1:0] START_A = ADDR_W'(START_OFS);

  initial begin
    a_r3_nch_range: assert (NCH == 2 || NCH == 3)
      else $error("channel count must be 2 or 3");
  end

  logic                     wr_en, rd_en;
  logic [NCH-1:0]           run_q;
  logic [NCH-1:0][DW-1:0]   rld_v, cnt_v;
  logic [NCH-1:0][CW-1:0]   ctl_v;
  logic [DW-1:0]            rd_mux;

  assign wr_en = bus_sel && bus_we;
  assign rd_en = bus_sel && !bus_we;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (wr_en && bus_size == SZ_BYTE && bus_addr == START_A)
      run_q <= bus_wdata[NCH-1:0];
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] RLD_A = ADDR_W'(CH_BASE + CH_STRIDE * n);
    localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(CH_BASE + CH_STRIDE * n + 4);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CH_BASE + CH_STRIDE * n + 8);

    tmr_channel i_ch (
      .clk    (clk),
      .rst    (rst),
      .run    (run_q[n]),
      .rld_we (wr_en && bus_size == SZ_WORD && bus_addr == RLD_A),
      .cnt_we (wr_en && bus_size == SZ_WORD && bus_addr == CNT_A),
      .ctl_we (wr_en && bus_size == SZ_HALF && bus_addr == CTL_A),
      .wdata  (bus_wdata),
      .rld_q  (rld_v[n]),
      .cnt_q  (cnt_v[n]),
      .ctl_rd (ctl_v[n]),
      .irq    (irq[n])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == START_A) rd_mux = DW'(run_q);
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n))     rd_mux = rld_v[n];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + 4)) rd_mux = cnt_v[n];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + 8)) rd_mux = DW'(ctl_v[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

  // r2: read data only changes in the cycle after a read request
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(bus_rdata));
  // r3: a write that does not hit the start byte leaves all run bits alone
  a_r3_run_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && bus_addr == START_A) |=> $stable(run_q));
endmodule

// File: tb/test_tick_timer_bank.sv
`timescale 1ns/1ps
module test_tick_timer_bank;
  localparam int NCH = 3;
  localparam int AW  = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]    bus_size = 2'd0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tick_timer_bank #(.NCH(NCH), .ADDR_W(AW)) i_tick_timer_bank (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int a_rld(int n); return 8 + 12*n; endfunction
  function automatic int a_cnt(int n); return 12 + 12*n; endfunction
  function automatic int a_ctl(int n); return 16 + 12*n; endfunction

  function automatic int div_of(int code);
    case (code)
      1: return 16; 2: return 64; 3: return 256; 4: return 1024;
      default: return 4;
    endcase
  endfunction

  function automatic logic [32:0] model(logic [31:0] c0, logic [31:0] k, int steps);
    logic [31:0] c = c0;
    logic f = 0;
    for (int t = 0; t < steps; t++) begin
      if (c == 0) begin c = k; f = 1; end
      else c = c - 1;
    end
    return {f, c};
  endfunction

  function automatic logic [31:0] ctl_word(int code, bit ie, bit fl);
    return {23'd0, fl, 2'b00, ie, 2'b00, 3'(code)};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(int addr, int sz, logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_size = 2'(sz); bus_addr = AW'(addr); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(int addr, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_size = 2'd2; bus_addr = AW'(addr);
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  // run the channels in mask for exactly n clock edges
  task automatic run_for(int mask, int n);
    wr(4, 0, 32'(mask));
    repeat (n - 1) @(negedge clk);
    wr(4, 0, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, other;
    logic [32:0] m;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(4, d); check("R1 start", d, 0);
    for (int n = 0; n < NCH; n++) begin
      rd(a_rld(n), d); check("R1 reload", d, 32'hFFFF_FFFF);
      rd(a_cnt(n), d); check("R1 counter", d, 32'hFFFF_FFFF);
      rd(a_ctl(n), d); check("R1 control", d, 0);
    end
    check("R1 irq", 32'(irq), 0);

    // R2 map and sizes, R9 reserved bits
    wr(a_rld(1), 2, 32'h1234_5678); rd(a_rld(1), d); check("R2 reload word", d, 32'h1234_5678);
    wr(a_rld(1), 0, 32'h0000_0011); rd(a_rld(1), d); check("R2 byte to reload ignored", d, 32'h1234_5678);
    wr(a_ctl(1), 2, 32'h0000_0021); rd(a_ctl(1), d); check("R2 word to control ignored", d, 0);
    wr(a_ctl(1), 1, 32'h0000_FFFF); rd(a_ctl(1), d); check("R9 control readback", d, 32'h0000_0027);
    wr(4, 2, 32'h1); rd(4, d); check("R2 word to start ignored", d, 0);
    rd(0, d); check("R2 unmapped", d, 0);
    wr(a_ctl(1), 1, 0);

    // R5 directed timing, divisor 4: start counter 1, reload 2
    wr(a_rld(0), 2, 2); wr(a_cnt(0), 2, 1); wr(a_ctl(0), 1, 0);
    run_for(1, 7);
    rd(a_cnt(0), d); check("R5 one step at edge 4", d, 0);
    rd(a_ctl(0), d); check("R5 no flag yet", d, 0);
    wr(a_cnt(0), 2, 1);
    run_for(1, 8);
    rd(a_cnt(0), d); check("R5 reload at second step", d, 2);
    rd(a_ctl(0), d); check("R7 flag set", d, ctl_word(0, 0, 1));
    check("R8 irq low without enable", 32'(irq[0]), 0);
    wr(a_ctl(0), 1, ctl_word(0, 1, 1));
    check("R8 irq with enable", 32'(irq[0]), 1);
    check("R7 write of one keeps flag", 32'(irq[0]), 1);
    wr(a_ctl(0), 1, ctl_word(0, 1, 0));
    check("R7 write of zero clears", 32'(irq[0]), 0);
    repeat (40) @(negedge clk);
    rd(a_cnt(0), d); check("R4 stopped counter holds", d, 2);

    // R6 reserved code behaves as divisor 4
    wr(a_ctl(2), 1, ctl_word(6, 0, 0)); wr(a_cnt(2), 2, 20);
    run_for(4, 12);
    rd(a_cnt(2), d); check("R6 code 6 divides by 4", d, 17);

    // R3 only channel 1 runs
    rd(a_cnt(0), other);
    wr(a_ctl(1), 1, 0); wr(a_cnt(1), 2, 9);
    run_for(2, 20);
    rd(a_cnt(1), d); check("R3 channel 1 ran", d, 4);
    rd(a_cnt(0), d); check("R3 channel 0 untouched", d, other);

    // random runs
    for (int it = 0; it < 25; it++) begin
      int ch = $urandom_range(NCH - 1);
      int code = $urandom_range(7);
      int n = $urandom_range(400, 1);
      bit ie = 1'($urandom_range(1));
      logic [31:0] k = 32'($urandom_range(15));
      logic [31:0] c0 = 32'($urandom_range(15));
      int oc = (ch + 1) % NCH;
      wr(a_ctl(ch), 1, ctl_word(code, ie, 0));
      wr(a_rld(ch), 2, k);
      wr(a_cnt(ch), 2, c0);
      rd(a_cnt(oc), other);
      run_for(1 << ch, n);
      m = model(c0, k, n / div_of(code));
      rd(a_cnt(ch), d); check("R5 R6 R4 random counter", d, m[31:0]);
      rd(a_ctl(ch), d); check("R7 random flag", d, ctl_word(code, ie, m[32]));
      check("R8 random irq", 32'(irq[ch]), 32'(m[32] & ie));
      rd(a_cnt(oc), d); check("R3 random other channel", d, other);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule